// File: doc/BRIEF.md
# Mesh Neighbor Link Unit

This unit sits beside one core in a two-dimensional grid of cores (eight by eight by default). The core exchanges words with the four cores next to it, and there is no router. An explicit send instruction places a word on the outgoing link toward one neighbor. An explicit receive instruction takes the oldest word that neighbor has delivered. Each incoming side has its own small FIFO, so a neighbor can deliver words before the core asks for them.

When a receive finds the FIFO empty, the core is stalled. When a send meets a neighbor whose FIFO is full, the core is also stalled. The grid does not wrap around, so a core on the grid edge has no neighbor on its outer side. A send or receive aimed at that missing side is dropped and raises an error flag.

The unit also gives the core its port into the single chip-wide barrier. It raises an arrival flag toward the combining tree and holds the core until the release comes back. It then refuses to join another barrier until the core has withdrawn its request.

Top module: `mesh_link_node`

## Requirements
- R1: Directions are coded 0 north, 1 east, 2 south, 3 west. This code also indexes bit d of every four-bit link vector, and bits d*DATA_W and up of every packed link data bus. A send with `snd_valid_i` high to a present direction d raises `out_valid_o[d]` in the same cycle and puts `snd_data_i` on lane d. All other `out_valid_o` bits stay low.
- R2: `snd_stall_o` is high exactly when a send to a present direction finds `out_ready_i` of that direction low. The send completes in the cycle when ready is high.
- R3: `in_ready_o[d]` of a present direction is high exactly while that direction's FIFO holds fewer than DEPTH words (default 4). A word is stored when `in_valid_i[d]` and `in_ready_o[d]` are both high.
- R4: A receive from a present direction with a non-empty FIFO returns that FIFO's oldest word on `rcv_data_o` in the same cycle and removes it. Words from one neighbor come out in arrival order, with none lost or repeated.
- R5: A receive from a present direction whose FIFO is empty raises `rcv_stall_o` and removes nothing.
- R6: On a missing side (first row has no north, last row no south, first column no west, last column no east), a send or receive is dropped without stall or link activity. `err_o` is high in the following cycle, `in_ready_o` of that side is held low, and its `in_valid_i` is ignored.
- R7: A barrier request raises `bar_arrive_o` one cycle later. The flag stays high until a cycle with `bar_release_i` high. `bar_stall_o` is high while the request waits.
- R8: After a release, `bar_arrive_o` and `bar_stall_o` stay low for as long as `bar_req_i` remains high. Only a request that is dropped and raised again starts a new barrier.
- R9: After reset every FIFO is empty, `in_ready_o` equals the present-side mask, and `err_o`, `bar_arrive_o` and all `out_valid_o` bits are low.
- R10: A FIFO that takes an incoming word and serves a receive in the same cycle keeps its fill level, and the new word goes behind the older ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| snd_valid_i | input | 1 | Core issues a send this cycle |
| snd_dir_i | input | 2 | Send direction (0 N, 1 E, 2 S, 3 W) |
| snd_data_i | input | DATA_W | Word to send |
| snd_stall_o | output | 1 | Send must be held, neighbor not ready |
| rcv_valid_i | input | 1 | Core issues a receive this cycle |
| rcv_dir_i | input | 2 | Receive direction |
| rcv_data_o | output | DATA_W | Oldest word from that direction |
| rcv_stall_o | output | 1 | Receive must be held, FIFO empty |
| err_o | output | 1 | Previous cycle addressed a missing side |
| out_valid_o | output | 4 | Outgoing word valid, one bit per side |
| out_data_o | output | 4*DATA_W | Outgoing word lanes, one per side |
| out_ready_i | input | 4 | Neighbor can take a word, one bit per side |
| in_valid_i | input | 4 | Incoming word valid, one bit per side |
| in_data_i | input | 4*DATA_W | Incoming word lanes |
| in_ready_o | output | 4 | FIFO of that side has room |
| bar_req_i | input | 1 | Core requests the barrier |
| bar_stall_o | output | 1 | Core held at the barrier |
| bar_arrive_o | output | 1 | Arrival flag toward the combining tree |
| bar_release_i | input | 1 | Release broadcast from the tree |

## Verification
The bench drives phases in which the FIFOs are flooded and starved, so the full and empty boundaries are crossed many times. A design with an off-by-one fill count would drop a fifth word or stall a receive too early. A design that mishandles push and pop in the same cycle would drift its count or reorder words. Sends and receives go to the missing north side of a first-row core, which catches a design that stalls there, drives the link, or forgets the error flag. The barrier request is held long past a release, so a design that rearms without seeing the request drop would raise arrival a second time.

// File: rtl/mesh_link_pkg.sv
// Shared definitions for the mesh neighbor link unit.
// Assumes a rectangular grid without wraparound links.
package mesh_link_pkg;

    // Side codes; the value also indexes the four-bit link vectors.
    localparam int SIDE_N = 0;
    localparam int SIDE_E = 1;
    localparam int SIDE_S = 2;
    localparam int SIDE_W = 3;

    typedef enum logic [1:0] {
        BAR_IDLE = 2'd0,
        BAR_WAIT = 2'd1,
        BAR_DONE = 2'd2
    } bar_state_e;

    // Mask of sides that have a neighbor, for a core at (row, col).
    function automatic logic [3:0] side_mask(input int row, input int col,
                                             input int rows, input int cols);
        logic [3:0] m;
        m[SIDE_N] = (row > 0);
        m[SIDE_S] = (row < rows - 1);
        m[SIDE_W] = (col > 0);
        m[SIDE_E] = (col < cols - 1);
        return m;
    endfunction

endpackage

// File: rtl/mesh_link_fifo.sv
// Receive buffer for one side: a small circular FIFO with first-word
// fall-through on head_o.
// Assumes the caller pushes only when not full and pops only when not empty.
module mesh_link_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              pop_i,
    output logic              full_o,
    output logic              empty_o,
    output logic [DATA_W-1:0] head_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_q, rd_q;
    logic [CW-1:0]     cnt_q;

    assign full_o  = (cnt_q == FULL_CNT);
    assign empty_o = (cnt_q == '0);
    assign head_o  = mem[rd_q];

    // Storage write; no reset needed for the data array.
    always_ff @(posedge clk) begin
        if (push_i) mem[wr_q] <= data_i;
    end

    // Pointer and fill-level update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_i) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
            if (pop_i)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
            case ({push_i, pop_i})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (cnt_q < FULL_CNT)); // R3
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (cnt_q != '0)); // R5
    AST_LEVEL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i) |=> $stable(cnt_q)); // R10

endmodule

// File: rtl/mesh_barrier_port.sv
// Per-core port into the global barrier tree. Raises arrival after a
// request, holds the core until release, then waits for the request to
// drop before it can arm again.
// Assumes the core keeps bar_req_i high while bar_stall_o is high.
module mesh_barrier_port
    import mesh_link_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic release_i,
    output logic arrive_o,
    output logic stall_o
);
    bar_state_e st_q;

    assign arrive_o = (st_q == BAR_WAIT);
    assign stall_o  = req_i && (st_q != BAR_DONE);

    // Barrier sequence: idle -> waiting -> done -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= BAR_IDLE;
        end else begin
            case (st_q)
                BAR_IDLE: if (req_i)     st_q <= BAR_WAIT;
                BAR_WAIT: if (release_i) st_q <= BAR_DONE;
                BAR_DONE: if (!req_i)    st_q <= BAR_IDLE;
                default:                 st_q <= BAR_IDLE;
            endcase
        end
    end

    AST_ARRIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (arrive_o && !release_i) |=> arrive_o); // R7
    AST_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (arrive_o && release_i && req_i) |=> (!arrive_o && !stall_o)); // R8

endmodule

// File: rtl/mesh_link_node.sv
// Neighbor link unit for one core of a 2D mesh without wraparound.
// Four receive FIFOs (one per side), direct send lanes toward each
// neighbor, edge-side error reporting, and the barrier port.
// Assumes neighbors hold a word on their lane until it is accepted.
module mesh_link_node
    import mesh_link_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    parameter int ROWS   = 8,
    parameter int COLS   = 8,
    parameter int ROW    = 0,
    parameter int COL    = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                snd_valid_i,
    input  logic [1:0]          snd_dir_i,
    input  logic [DATA_W-1:0]   snd_data_i,
    output logic                snd_stall_o,
    input  logic                rcv_valid_i,
    input  logic [1:0]          rcv_dir_i,
    output logic [DATA_W-1:0]   rcv_data_o,
    output logic                rcv_stall_o,
    output logic                err_o,
    output logic [3:0]          out_valid_o,
    output logic [4*DATA_W-1:0] out_data_o,
    input  logic [3:0]          out_ready_i,
    input  logic [3:0]          in_valid_i,
    input  logic [4*DATA_W-1:0] in_data_i,
    output logic [3:0]          in_ready_o,
    input  logic                bar_req_i,
    output logic                bar_stall_o,
    output logic                bar_arrive_o,
    input  logic                bar_release_i
);
    localparam logic [3:0] HAVE = side_mask(ROW, COL, ROWS, COLS);

    logic [3:0]        empty_w;
    logic [DATA_W-1:0] head_w [4];
    logic              snd_ok, rcv_ok, err_q;

    assign snd_ok = HAVE[snd_dir_i];
    assign rcv_ok = HAVE[rcv_dir_i];

    // Core-side handshake outputs.
    assign snd_stall_o = snd_valid_i && snd_ok && !out_ready_i[snd_dir_i];
    assign rcv_stall_o = rcv_valid_i && rcv_ok && empty_w[rcv_dir_i];
    assign rcv_data_o  = head_w[rcv_dir_i];
    assign err_o       = err_q;

    for (genvar d = 0; d < 4; d++) begin : g_side
        assign out_valid_o[d] = snd_valid_i && HAVE[d] && (snd_dir_i == 2'(d));
        assign out_data_o[d*DATA_W +: DATA_W] = snd_data_i;

        if (HAVE[d]) begin : g_link
            logic full_w, push_w, pop_w;
            assign push_w        = in_valid_i[d] && !full_w;
            assign pop_w         = rcv_valid_i && (rcv_dir_i == 2'(d)) && !empty_w[d];
            assign in_ready_o[d] = !full_w;

            mesh_link_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
                .clk     (clk),
                .rst_n   (rst_n),
                .push_i  (push_w),
                .data_i  (in_data_i[d*DATA_W +: DATA_W]),
                .pop_i   (pop_w),
                .full_o  (full_w),
                .empty_o (empty_w[d]),
                .head_o  (head_w[d])
            );
        end else begin : g_edge
            assign in_ready_o[d] = 1'b0;
            assign empty_w[d]    = 1'b1;
            assign head_w[d]     = '0;
        end
    end

    // Flag any access aimed at a side without a neighbor.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= (snd_valid_i && !snd_ok) || (rcv_valid_i && !rcv_ok);
    end

    mesh_barrier_port u_bar (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (bar_req_i),
        .release_i (bar_release_i),
        .arrive_o  (bar_arrive_o),
        .stall_o   (bar_stall_o)
    );

    AST_ERR_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ((snd_valid_i && !snd_ok) || (rcv_valid_i && !rcv_ok)) |=> err_o); // R6
    AST_SEND_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_valid_o)); // R1
    AST_EDGE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_valid_i && !snd_ok) |-> !snd_stall_o); // R6

endmodule

// File: tb/mesh_link_node_tb.sv
// Bench for mesh_link_node: a behavioural reference (queues and a state
// integer) is stepped every cycle and compared against all outputs.
module mesh_link_node_tb_top;
    localparam int  W      = 32;
    localparam time PERIOD = 10ns;
    // Core at row 0, column 3 of an 8x8 grid: north is missing.
    localparam logic [3:0] HAVE_EXP = 4'b1110;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           snd_valid = 1'b0, rcv_valid = 1'b0;
    logic [1:0]     snd_dir = '0, rcv_dir = '0;
    logic [W-1:0]   snd_data = '0, rcv_data;
    logic           snd_stall, rcv_stall, err;
    logic [3:0]     out_valid, out_ready = '0, in_valid = '0, in_ready;
    logic [4*W-1:0] out_data, in_data = '0;
    logic           bar_req = 1'b0, bar_stall, bar_arrive, bar_release = 1'b0;

    int n_run = 0, n_fail = 0;

    always #(PERIOD/2) clk = ~clk;

    mesh_link_node #(.DATA_W(W), .DEPTH(4), .ROWS(8), .COLS(8), .ROW(0), .COL(3)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .snd_valid_i(snd_valid), .snd_dir_i(snd_dir), .snd_data_i(snd_data),
        .snd_stall_o(snd_stall),
        .rcv_valid_i(rcv_valid), .rcv_dir_i(rcv_dir), .rcv_data_o(rcv_data),
        .rcv_stall_o(rcv_stall), .err_o(err),
        .out_valid_o(out_valid), .out_data_o(out_data), .out_ready_i(out_ready),
        .in_valid_i(in_valid), .in_data_i(in_data), .in_ready_o(in_ready),
        .bar_req_i(bar_req), .bar_stall_o(bar_stall), .bar_arrive_o(bar_arrive),
        .bar_release_i(bar_release)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Reference model state.
    logic [W-1:0] rxq [4][$];
    logic         err_exp = 1'b0;
    int           bst = 0; // 0 idle, 1 waiting, 2 released

    initial begin
        #(PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int p_snd, p_rdy, p_in, p_rcv;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk("R9", "in_ready after reset", 64'(in_ready), 64'(HAVE_EXP));
        chk("R9", "err after reset", 64'(err), 64'd0);
        chk("R9", "arrive after reset", 64'(bar_arrive), 64'd0);
        chk("R9", "out_valid after reset", 64'(out_valid), 64'd0);
        rst_n = 1'b1;

        for (int ph = 0; ph < 5; ph++) begin
            case (ph)
                0: begin p_snd = 50; p_rdy = 70; p_in = 50; p_rcv = 50; end
                1: begin p_snd = 30; p_rdy = 20; p_in = 90; p_rcv = 10; end
                2: begin p_snd = 60; p_rdy = 90; p_in = 5;  p_rcv = 90; end
                3: begin p_snd = 40; p_rdy = 50; p_in = 80; p_rcv = 80; end
                default: begin p_snd = 80; p_rdy = 40; p_in = 60; p_rcv = 60; end
            endcase
            for (int cyc = 0; cyc < 400; cyc++) begin
                @(negedge clk);
                // Drive the core, the neighbors and the barrier tree.
                snd_valid = ($urandom % 100) < p_snd;
                snd_dir   = 2'($urandom % 4);
                snd_data  = $urandom;
                rcv_valid = ($urandom % 100) < p_rcv;
                rcv_dir   = 2'($urandom % 4);
                for (int d = 0; d < 4; d++) begin
                    out_ready[d] = ($urandom % 100) < p_rdy;
                    in_valid[d]  = ($urandom % 100) < p_in;
                    in_data[d*W +: W] = $urandom;
                end
                if (bst == 0)      bar_req = bar_req ? 1'b1 : (($urandom % 4) == 0);
                else if (bst == 2) bar_req = (($urandom % 3) != 0);
                if (bst == 0 && !bar_req) bar_req = 1'b0;
                bar_release = (($urandom % 6) == 0);
                #1;

                // Compare against the model.
                for (int d = 0; d < 4; d++) begin
                    chk("R3/R10", $sformatf("in_ready[%0d]", d), 64'(in_ready[d]),
                        64'(HAVE_EXP[d] && rxq[d].size() < 4));
                    chk("R1", $sformatf("out_valid[%0d]", d), 64'(out_valid[d]),
                        64'(snd_valid && HAVE_EXP[d] && snd_dir == 2'(d)));
                end
                if (snd_valid && HAVE_EXP[snd_dir])
                    chk("R1", "out_data lane", 64'(out_data[snd_dir*W +: W]), 64'(snd_data));
                chk("R2", "snd_stall", 64'(snd_stall),
                    64'(snd_valid && HAVE_EXP[snd_dir] && !out_ready[snd_dir]));
                chk("R5", "rcv_stall", 64'(rcv_stall),
                    64'(rcv_valid && HAVE_EXP[rcv_dir] && rxq[rcv_dir].size() == 0));
                if (rcv_valid && HAVE_EXP[rcv_dir] && rxq[rcv_dir].size() > 0)
                    chk("R4", "rcv_data oldest word", 64'(rcv_data), 64'(rxq[rcv_dir][0]));
                chk("R6", "err flag", 64'(err), 64'(err_exp));
                chk("R7", "bar_arrive", 64'(bar_arrive), 64'(bst == 1));
                chk("R8", "bar_stall", 64'(bar_stall), 64'(bar_req && bst != 2));

                // Advance the model to the next clock edge.
                err_exp = (snd_valid && !HAVE_EXP[snd_dir]) || (rcv_valid && !HAVE_EXP[rcv_dir]);
                begin
                    logic [3:0] push;
                    for (int d = 0; d < 4; d++)
                        push[d] = in_valid[d] && HAVE_EXP[d] && rxq[d].size() < 4;
                    if (rcv_valid && HAVE_EXP[rcv_dir] && rxq[rcv_dir].size() > 0)
                        void'(rxq[rcv_dir].pop_front());
                    for (int d = 0; d < 4; d++)
                        if (push[d]) rxq[d].push_back(in_data[d*W +: W]);
                end
                case (bst)
                    0: if (bar_req) bst = 1;
                    1: if (bar_release) bst = 2;
                    default: if (!bar_req) bst = 0;
                endcase
            end
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule